// File: doc/BRIEF.md
# Pixel Clock Divider Search Engine

This block picks the divider settings for a pixel clock synthesizer. Given a requested pixel clock in kHz, it tries every combination of post-divider P, reference divider M and feedback multiplier N. Each candidate gives an output frequency of reference × N / (M × P), computed in integers. The block returns the combination whose frequency is nearest to the request. The spare S field of the result is always zero.

A one-cycle `start` pulse latches the request and begins the search. The block then works through the candidates one at a time, using a restoring divider that takes a fixed number of cycles per candidate. A one-cycle `done` pulse marks the result. The reference frequency, the VCO window and the three loop limits are parameters.

A post-divider value is searched only when request × P lies inside the VCO window. If no P value qualifies, the result is all zero.

Top module: `pll_search_top`

## Requirements
- R1: Each candidate frequency is floor(REF_KHZ × N / (M × P)). The returned set gives the smallest absolute difference between that frequency and the latched request, over all candidates that are searched.
- R2: Candidates are visited with P outermost (1..P_LIMIT), then M (1..M_LIMIT), then N innermost (1..N_LIMIT). The best set is replaced only on a strictly smaller error, so on a tie the earliest candidate in this order is returned.
- R3: A P value is searched only if VCO_MIN_KHZ ≤ request × P ≤ VCO_MAX_KHZ, with both bounds inclusive.
- R4: If no P value passes the R3 window, `mOut`, `nOut`, `pOut` and `sOut` are all zero.
- R5: `sOut` is always zero.
- R6: `done` is high for exactly one cycle per accepted search. The result outputs are valid in that cycle, and they change only in a cycle where `done` is high.
- R7: A `start` pulse that arrives while a search is running is ignored. It does not change the running search's result and produces no extra `done`.
- R8: With K passing P values, `done` rises no later than (P_LIMIT + 2) + K × M_LIMIT × N_LIMIT × (DW + 2) cycles after the start edge. DW is the bit width of REF_KHZ × N_LIMIT.
- R9: After reset, `done` is low and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin a search; ignored while busy |
| reqKhz | input | REQ_W | Requested pixel clock in kHz, latched on an accepted start |
| done | output | 1 | One-cycle pulse; result valid in this cycle |
| mOut | output | $clog2(M_LIMIT+1) | Chosen reference divider M (0 if no P passes) |
| nOut | output | $clog2(N_LIMIT+1) | Chosen feedback multiplier N (0 if no P passes) |
| pOut | output | $clog2(P_LIMIT+1) | Chosen post-divider P (0 if no P passes) |
| sOut | output | 2 | Spare field, always zero |

## Verification
The bench keeps the 48000 kHz reference, the 150000..550000 kHz VCO window and the full P range of 1..8. The VCO gating, its inclusive edges and the empty-result cases therefore behave exactly as at the defaults.

It narrows M to 1..3 and N to 1..10. This brings each search down to a few thousand cycles, so a dozen requests fit in one run and each can be compared against a reference model inside the bench. The narrowed limits still contain several exact ties, for example 48000 kHz reached at both M=1,N=4 and M=2,N=8 with P=4. This lets the bench check the first-found rule, as well as the latency bound for each request.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PCHK,
    ST_LOAD,
    ST_DIV
  } ctrlState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic init;    // clear the running best at search start
    logic load;    // launch the divider on the current candidate
    logic cmp;     // divider result ready: score the candidate
    logic finish;  // search over: publish best and pulse done
  } strobe_t;

endpackage

// File: rtl/pll_div_restore.sv
module pll_div_restore #(
  parameter int NUM_W = 23,
  parameter int DEN_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo,
  output logic             fin
);

  localparam int CW = $clog2(NUM_W + 1);
  localparam int PW = NUM_W + DEN_W + 1;

  logic [DEN_W-1:0] remR;
  logic [NUM_W-1:0] quoR;
  logic [NUM_W-1:0] numR;
  logic [DEN_W-1:0] denR;
  logic [CW-1:0]    cnt;
  logic [DEN_W:0]   shifted;
  logic [DEN_W:0]   newRem;
  logic             geq;

  assign shifted = {remR, quoR[NUM_W-1]};
  assign geq     = shifted >= {1'b0, denR};
  assign newRem  = geq ? (shifted - {1'b0, denR}) : shifted;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remR <= '0;
      quoR <= '0;
      numR <= '0;
      denR <= '0;
      cnt  <= '0;
      fin  <= 1'b0;
    end else if (load) begin
      remR <= '0;
      quoR <= num;
      numR <= num;
      denR <= den;
      cnt  <= CW'(NUM_W);
      fin  <= 1'b0;
    end else if (cnt != '0) begin
      remR <= newRem[DEN_W-1:0];
      quoR <= {quoR[NUM_W-2:0], geq};
      cnt  <= cnt - 1'b1;
      fin  <= (cnt == CW'(1));
    end else begin
      fin  <= 1'b0;
    end
  end

  assign quo = quoR;

  logic [PW-1:0] lowProd;
  logic [PW-1:0] highProd;
  logic [PW-1:0] numExt;
  assign lowProd  = PW'(quoR) * PW'(denR);
  assign highProd = lowProd + PW'(denR);
  assign numExt   = PW'(numR);

  // R1
  div_quotient_chk: assert property (@(posedge clk) disable iff (!rstN)
    fin |-> (lowProd <= numExt) && (numExt < highProd));

endmodule

// File: rtl/pll_search_ctrl.sv
module pll_search_ctrl
  import pll_search_pkg::*;
#(
  parameter int P_LIMIT     = 8,
  parameter int M_LIMIT     = 16,
  parameter int N_LIMIT     = 150,
  parameter int VCO_MIN_KHZ = 150000,
  parameter int VCO_MAX_KHZ = 550000,
  parameter int REQ_W       = 20,
  localparam int PW  = $clog2(P_LIMIT + 1),
  localparam int MW  = $clog2(M_LIMIT + 1),
  localparam int NW  = $clog2(N_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [REQ_W-1:0] reqKhz,
  input  logic             divFin,
  output strobe_t          strb,
  output logic [PW-1:0]    candP,
  output logic [MW-1:0]    candM,
  output logic [NW-1:0]    candN,
  output logic [REQ_W-1:0] reqHeld
);

  localparam int PCW = $clog2(P_LIMIT + 2);

  ctrlState_t         state;
  logic [PCW-1:0]     pCnt;
  logic [MW-1:0]      mCnt;
  logic [NW-1:0]      nCnt;
  logic [63:0]        vcoProd;
  logic               vcoOk;
  logic               pDone;
  logic               busy;

  assign vcoProd = 64'(reqHeld) * 64'(pCnt);
  assign vcoOk   = (vcoProd >= 64'(VCO_MIN_KHZ)) && (vcoProd <= 64'(VCO_MAX_KHZ));
  assign pDone   = pCnt > PCW'(P_LIMIT);
  assign busy    = state != ST_IDLE;

  always_comb begin
    strb        = '0;
    strb.init   = (state == ST_IDLE) && start;
    strb.load   = (state == ST_LOAD);
    strb.cmp    = (state == ST_DIV) && divFin;
    strb.finish = (state == ST_PCHK) && pDone;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      pCnt    <= PCW'(1);
      mCnt    <= MW'(1);
      nCnt    <= NW'(1);
      reqHeld <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          reqHeld <= reqKhz;
          pCnt    <= PCW'(1);
          mCnt    <= MW'(1);
          nCnt    <= NW'(1);
          state   <= ST_PCHK;
        end
        ST_PCHK: begin
          if (pDone)      state <= ST_IDLE;
          else if (vcoOk) state <= ST_LOAD;
          else            pCnt  <= pCnt + 1'b1;
        end
        ST_LOAD: state <= ST_DIV;
        ST_DIV: if (divFin) begin
          if (nCnt != NW'(N_LIMIT)) begin
            nCnt  <= nCnt + 1'b1;
            state <= ST_LOAD;
          end else begin
            nCnt <= NW'(1);
            if (mCnt != MW'(M_LIMIT)) begin
              mCnt  <= mCnt + 1'b1;
              state <= ST_LOAD;
            end else begin
              mCnt  <= MW'(1);
              pCnt  <= pCnt + 1'b1;
              state <= ST_PCHK;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign candP = pCnt[PW-1:0];
  assign candM = mCnt;
  assign candN = nCnt;

  // R3
  load_in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |-> vcoOk && (pCnt >= PCW'(1)) && !pDone);

  // R7
  req_locked_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(reqHeld));

endmodule

// File: rtl/pll_search_dp.sv
module pll_search_dp
  import pll_search_pkg::*;
#(
  parameter int REF_KHZ     = 48000,
  parameter int P_LIMIT     = 8,
  parameter int M_LIMIT     = 16,
  parameter int N_LIMIT     = 150,
  parameter int VCO_MIN_KHZ = 150000,
  parameter int VCO_MAX_KHZ = 550000,
  parameter int REQ_W       = 20,
  parameter int ERR_W       = 32,
  localparam int PW  = $clog2(P_LIMIT + 1),
  localparam int MW  = $clog2(M_LIMIT + 1),
  localparam int NW  = $clog2(N_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [PW-1:0]    candP,
  input  logic [MW-1:0]    candM,
  input  logic [NW-1:0]    candN,
  input  logic [REQ_W-1:0] reqHeld,
  output logic             divFin,
  output logic             done,
  output logic [MW-1:0]    mOut,
  output logic [NW-1:0]    nOut,
  output logic [PW-1:0]    pOut,
  output logic [1:0]       sOut
);

  localparam int DVD_W = $clog2(REF_KHZ * N_LIMIT + 1);
  localparam int DVS_W = $clog2(M_LIMIT * P_LIMIT + 1);

  logic [DVD_W-1:0] divNum;
  logic [DVS_W-1:0] divDen;
  logic [DVD_W-1:0] divQuo;
  logic [ERR_W-1:0] candF;
  logic [ERR_W-1:0] reqF;
  logic [ERR_W-1:0] candErr;
  logic [ERR_W-1:0] bestErr;
  logic [MW-1:0]    bestM;
  logic [NW-1:0]    bestN;
  logic [PW-1:0]    bestP;

  assign divNum = DVD_W'(REF_KHZ) * DVD_W'(candN);
  assign divDen = DVS_W'(candM) * DVS_W'(candP);

  pll_div_restore #(.NUM_W(DVD_W), .DEN_W(DVS_W)) uDiv (
    .clk  (clk),
    .rstN (rstN),
    .load (strb.load),
    .num  (divNum),
    .den  (divDen),
    .quo  (divQuo),
    .fin  (divFin)
  );

  assign candF   = ERR_W'(divQuo);
  assign reqF    = ERR_W'(reqHeld);
  assign candErr = (candF > reqF) ? (candF - reqF) : (reqF - candF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bestErr <= '1;
      bestM   <= '0;
      bestN   <= '0;
      bestP   <= '0;
      mOut    <= '0;
      nOut    <= '0;
      pOut    <= '0;
      done    <= 1'b0;
    end else begin
      done <= strb.finish;
      if (strb.init) begin
        bestErr <= '1;
        bestM   <= '0;
        bestN   <= '0;
        bestP   <= '0;
      end else if (strb.cmp && (candErr < bestErr)) begin
        bestErr <= candErr;
        bestM   <= candM;
        bestN   <= candN;
        bestP   <= candP;
      end
      if (strb.finish) begin
        mOut <= bestM;
        nOut <= bestN;
        pOut <= bestP;
      end
    end
  end

  assign sOut = 2'b00;

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable({mOut, nOut, pOut}));

  // R4
  empty_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && (pOut == '0)) |-> (mOut == '0) && (nOut == '0));

  // R3
  result_vco_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && (pOut != '0)) |->
      (64'(reqHeld) * 64'(pOut) >= 64'(VCO_MIN_KHZ)) &&
      (64'(reqHeld) * 64'(pOut) <= 64'(VCO_MAX_KHZ)));

endmodule

// File: rtl/pll_search_top.sv
module pll_search_top
  import pll_search_pkg::*;
#(
  parameter int REF_KHZ     = 48000,
  parameter int VCO_MIN_KHZ = 150000,
  parameter int VCO_MAX_KHZ = 550000,
  parameter int P_LIMIT     = 8,
  parameter int M_LIMIT     = 16,
  parameter int N_LIMIT     = 150,
  parameter int REQ_W       = 20,
  parameter int ERR_W       = 32,
  localparam int PW  = $clog2(P_LIMIT + 1),
  localparam int MW  = $clog2(M_LIMIT + 1),
  localparam int NW  = $clog2(N_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [REQ_W-1:0] reqKhz,
  output logic             done,
  output logic [MW-1:0]    mOut,
  output logic [NW-1:0]    nOut,
  output logic [PW-1:0]    pOut,
  output logic [1:0]       sOut
);

  strobe_t          strb;
  logic [PW-1:0]    candP;
  logic [MW-1:0]    candM;
  logic [NW-1:0]    candN;
  logic [REQ_W-1:0] reqHeld;
  logic             divFin;

  pll_search_ctrl #(
    .P_LIMIT(P_LIMIT), .M_LIMIT(M_LIMIT), .N_LIMIT(N_LIMIT),
    .VCO_MIN_KHZ(VCO_MIN_KHZ), .VCO_MAX_KHZ(VCO_MAX_KHZ), .REQ_W(REQ_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .reqKhz(reqKhz), .divFin(divFin),
    .strb(strb), .candP(candP), .candM(candM), .candN(candN), .reqHeld(reqHeld)
  );

  pll_search_dp #(
    .REF_KHZ(REF_KHZ), .P_LIMIT(P_LIMIT), .M_LIMIT(M_LIMIT), .N_LIMIT(N_LIMIT),
    .VCO_MIN_KHZ(VCO_MIN_KHZ), .VCO_MAX_KHZ(VCO_MAX_KHZ),
    .REQ_W(REQ_W), .ERR_W(ERR_W)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .candP(candP), .candM(candM),
    .candN(candN), .reqHeld(reqHeld), .divFin(divFin), .done(done),
    .mOut(mOut), .nOut(nOut), .pOut(pOut), .sOut(sOut)
  );

endmodule

// File: tb/tb_pll_search_top.sv
module tb_pll_search_top;

  localparam int REF  = 48000;
  localparam int VMIN = 150000;
  localparam int VMAX = 550000;
  localparam int PL   = 8;
  localparam int ML   = 3;
  localparam int NL   = 10;
  localparam int PW   = $clog2(PL + 1);
  localparam int MW   = $clog2(ML + 1);
  localparam int NW   = $clog2(NL + 1);
  localparam int DW   = $clog2(REF * NL + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [19:0] reqKhz = '0;
  logic done;
  logic [MW-1:0] mOut;
  logic [NW-1:0] nOut;
  logic [PW-1:0] pOut;
  logic [1:0] sOut;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pll_search_top #(
    .REF_KHZ(REF), .VCO_MIN_KHZ(VMIN), .VCO_MAX_KHZ(VMAX),
    .P_LIMIT(PL), .M_LIMIT(ML), .N_LIMIT(NL)
  ) dut (
    .clk(clk), .rstN(rstN), .start(start), .reqKhz(reqKhz), .done(done),
    .mOut(mOut), .nOut(nOut), .pOut(pOut), .sOut(sOut)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model(input int req, output int em, output int en,
                       output int ep, output int npass);
    longint best = 64'hFFFFFFFF;
    em = 0; en = 0; ep = 0; npass = 0;
    for (int p = 1; p <= PL; p++) begin
      longint v = longint'(req) * p;
      if (v > VMAX || v < VMIN) continue;
      npass++;
      for (int m = 1; m <= ML; m++) begin
        for (int n = 1; n <= NL; n++) begin
          longint c = (longint'(REF) * n) / (m * p);
          longint d = (c > req) ? c - req : req - c;
          if (d < best) begin
            best = d; em = m; en = n; ep = p;
          end
        end
      end
    end
  endtask

  task automatic runSearch(input int req, output int cyc);
    @(negedge clk);
    reqKhz = 20'(req);
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 60000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  // Full check of one request against the model (R1, R2, R3, R4, R5, R6, R8)
  task automatic testRequest(input int req);
    int em, en, ep, np, cyc, bound;
    model(req, em, en, ep, np);
    runSearch(req, cyc);
    check($sformatf("R6 done seen req=%0d", req), done, 1);
    check($sformatf("R1 M req=%0d", req), mOut, em);
    check($sformatf("R1 N req=%0d", req), nOut, en);
    check($sformatf("R3 P req=%0d", req), pOut, ep);
    check($sformatf("R5 S req=%0d", req), sOut, 0);
    bound = (PL + 2) + np * ML * NL * (DW + 2);
    check($sformatf("R8 latency within bound req=%0d", req), (cyc <= bound), 1);
    @(negedge clk);
    check($sformatf("R6 done one cycle req=%0d", req), done, 0);
  endtask

  task automatic testReset();
    check("R9 done after reset", done, 0);
    check("R9 M after reset", mOut, 0);
    check("R9 N after reset", nOut, 0);
    check("R9 P after reset", pOut, 0);
  endtask

  task automatic testEmpty(input int req);
    int cyc;
    runSearch(req, cyc);
    check($sformatf("R4 done req=%0d", req), done, 1);
    check($sformatf("R4 M zero req=%0d", req), mOut, 0);
    check($sformatf("R4 N zero req=%0d", req), nOut, 0);
    check($sformatf("R4 P zero req=%0d", req), pOut, 0);
    check($sformatf("R4 S zero req=%0d", req), sOut, 0);
    check($sformatf("R8 empty latency req=%0d", req), (cyc <= PL + 2), 1);
  endtask

  // 48000 kHz is exact at P=4,M=1,N=4 and again at P=4,M=2,N=8
  task automatic testTie();
    int cyc;
    runSearch(48000, cyc);
    check("R2 tie M", mOut, 1);
    check("R2 tie N", nOut, 4);
    check("R2 tie P", pOut, 4);
  endtask

  // VCO edges are inclusive
  task automatic testEdges();
    int cyc;
    runSearch(150000, cyc);
    check("R3 min edge P passes at 1", (pOut != 0), 1);
    runSearch(550000, cyc);
    check("R3 max edge P", pOut, 1);
    check("R3 max edge N", nOut, 10);
    check("R3 max edge M", mOut, 1);
  endtask

  task automatic testBusyStart();
    int em, en, ep, np, cyc, extra;
    model(74250, em, en, ep, np);
    @(negedge clk);
    reqKhz = 20'd74250;
    start  = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    reqKhz = 20'd108000;
    start  = 1'b1;
    @(negedge clk);
    start  = 1'b0;
    reqKhz = 20'd0;
    cyc = 0;
    while (!done && cyc < 60000) begin
      @(negedge clk);
      cyc++;
    end
    check("R7 M unaffected by busy start", mOut, em);
    check("R7 N unaffected by busy start", nOut, en);
    check("R7 P unaffected by busy start", pOut, ep);
    extra = 0;
    @(negedge clk);
    repeat (PL * ML * NL * (DW + 2) + 20) begin
      if (done) extra++;
      @(negedge clk);
    end
    check("R7 no extra done", extra, 0);
  endtask

  task automatic testHold();
    int cyc;
    logic [MW-1:0] m0;
    logic [NW-1:0] n0;
    logic [PW-1:0] p0;
    runSearch(65000, cyc);
    m0 = mOut; n0 = nOut; p0 = pOut;
    reqKhz = 20'd123456;
    repeat (30) @(negedge clk);
    check("R6 M held", mOut, m0);
    check("R6 N held", nOut, n0);
    check("R6 P held", pOut, p0);
    check("R6 done stays low", done, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRequest(25175);
    testRequest(40000);
    testRequest(65000);
    testRequest(108000);
    testRequest(150000);
    testRequest(550000);
    testTie();
    testEdges();
    testEmpty(0);
    testEmpty(550001);
    testEmpty(10000);
    testBusyStart();
    testHold();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule